// File: doc/BRIEF.md
# Sync-Locked Burst Scheduler

This block decides when a capacitive sensor front end runs its charge-transfer bursts, and it paces the transfer pulses inside each burst. After power-up it stays silent for a fixed holdoff. It then free-runs: each burst lasts until the charge comparator reports end of burst, and after that a fixed discharge gap passes before the next burst starts. When rising edges appear on the external sync input, for example a signal derived from the mains, the scheduler locks to them and starts a burst on each usable edge. If edges stop for longer than the loss timeout, it goes back to free-running.

Inside a burst, the transfer strobes are spaced by a period that hops pseudo-randomly within a fixed band of clock cycles. This spreads the emission spectrum. A burst whose comparator never fires is cut off after a maximum number of pulses, and that event is flagged. Every time is set by a parameter given in clock cycles. The defaults assume a 20 MHz clock: 200 ms holdoff, 2.5 ms gap, 100 ms loss timeout, and pulse periods of 66 to 86 cycles, which is roughly 232 to 303 kHz.

Top module: `burst_sched`

## Requirements
- R1: No burst starts before HOLDOFF_CYC clock cycles have passed since reset release. In free-running mode the first burst starts on exactly the HOLDOFF_CYC-th rising clock edge after release.
- R2: While free-running, burst_active stays low for exactly GAP_CYC cycles between the end of one burst and the start of the next.
- R3: While locked and waiting, a sync_in rising edge starts a burst 3 clock edges after the edge is applied (two synchronizer flops plus edge detection). With a steady sync period longer than burst plus gap, the bursts start exactly one sync period apart.
- R4: If no sync rising edge is detected for SYNC_TO_CYC cycles, the block falls back to free-running. The first free-running burst starts SYNC_TO_CYC+1 cycles after the edge that was last detected, and from then on the gaps equal GAP_CYC again.
- R5: Sync edges that arrive during a burst or during its gap do not trigger a burst. The first edge after the gap does. burst_active never stays low for less than GAP_CYC cycles between bursts.
- R6: Successive transfer pulses within a burst are spaced between PER_MIN and PER_MAX cycles, and the spacing varies from pulse to pulse. The first pulse comes PER_MIN-1 to PER_MAX-1 cycles after the burst starts.
- R7: A burst ends on the first clock edge at which eob is high while burst_active is high. No further pulse follows.
- R8: A burst that reaches MAX_PULSES pulses without eob ends on its last pulse. overflow is high for exactly that one cycle.
- R9: xfer_pulse is a single-cycle strobe that occurs only while burst_active is high. After reset, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_in | input | 1 | Asynchronous external sync; a rising edge requests a burst |
| eob | input | 1 | End-of-burst indication from the charge comparator |
| burst_active | output | 1 | High while an acquisition burst runs |
| xfer_pulse | output | 1 | One-cycle strobe for each charge-transfer cycle |
| overflow | output | 1 | High with the final pulse of a burst cut off at MAX_PULSES |

## Verification
On every cycle, the embedded assertions check the following:
- the holdoff before any burst;
- the minimum low time between bursts;
- the allowed range of pulse spacing;
- the single-cycle width of the strobe;
- that both eob and overflow end the burst on the next edge.

Only the bench scenarios can show the following:
- the exact free-running period;
- the edge-to-burst latency;
- that the start-to-start spacing follows a steady sync train;
- that edges are skipped when the sync train overclocks the bursts;
- the fallback time after the sync train stops;
- that the pulse spacing actually varies.

// File: rtl/burst_sched.sv
module burst_sched #(
  parameter int          HOLDOFF_CYC = 4_000_000,
  parameter int          GAP_CYC     = 50_000,
  parameter int          SYNC_TO_CYC = 2_000_000,
  parameter int          PER_MIN     = 66,
  parameter int          PER_MAX     = 86,
  parameter int          MAX_PULSES  = 65535,
  parameter logic [15:0] LFSR_SEED   = 16'hACE1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sync_in,
  input  logic eob,
  output logic burst_active,
  output logic xfer_pulse,
  output logic overflow
);
  localparam int HW   = $clog2(HOLDOFF_CYC + 1);
  localparam int GW   = $clog2(GAP_CYC + 1);
  localparam int TW   = $clog2(SYNC_TO_CYC + 1);
  localparam int PW   = $clog2(PER_MAX + 2);
  localparam int LW   = $clog2(MAX_PULSES + 1);
  localparam int SPAN = PER_MAX - PER_MIN + 1;

  typedef enum logic [1:0] {S_HOLD, S_WAIT, S_BURST, S_GAP} st_t;

  st_t           st;
  logic [2:0]    sync_q;
  logic          locked;
  logic [TW-1:0] tcnt;
  logic [HW-1:0] hcnt;
  logic [GW-1:0] gcnt;
  logic [PW-1:0] pcnt;
  logic [LW-1:0] plen;
  logic [15:0]   lfsr;
  logic [PW-1:0] hop, per;
  logic          sync_rise, hold_last, gap_last, start_burst;

  assign sync_rise    = sync_q[1] & ~sync_q[2];
  assign hop          = PW'(({24'd0, lfsr[7:0]} * SPAN) >> 8);
  assign per          = PW'(PER_MIN) + hop;
  assign hold_last    = (hcnt == HW'(HOLDOFF_CYC - 1));
  assign gap_last     = (gcnt == GW'(GAP_CYC - 1));
  assign burst_active = (st == S_BURST);
  assign xfer_pulse   = burst_active && (pcnt == '0);
  assign overflow     = xfer_pulse && (plen == LW'(MAX_PULSES - 1));
  assign start_burst  = (st == S_HOLD && hold_last && !locked) ||
                        (st == S_WAIT && (sync_rise || !locked)) ||
                        (st == S_GAP  && gap_last && !locked);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_HOLD;
      sync_q <= '0;
      locked <= 1'b0;
      tcnt   <= '0;
      hcnt   <= '0;
      gcnt   <= '0;
      pcnt   <= '0;
      plen   <= '0;
      lfsr   <= LFSR_SEED;
    end else begin
      sync_q <= {sync_q[1:0], sync_in};
      lfsr   <= {1'b0, lfsr[15:1]} ^ (lfsr[0] ? 16'hB400 : 16'h0000);

      if (sync_rise) begin
        locked <= 1'b1;
        tcnt   <= '0;
      end else if (locked) begin
        if (tcnt == TW'(SYNC_TO_CYC - 1)) locked <= 1'b0;
        else tcnt <= tcnt + TW'(1);
      end

      unique case (st)
        S_HOLD: begin
          if (hold_last) st <= S_WAIT;
          else hcnt <= hcnt + HW'(1);
        end
        S_WAIT: ;
        S_BURST: begin
          if (xfer_pulse) begin
            pcnt <= per - PW'(1);
            plen <= plen + LW'(1);
          end else begin
            pcnt <= pcnt - PW'(1);
          end
          if (eob || overflow) begin
            st   <= S_GAP;
            gcnt <= '0;
          end
        end
        S_GAP: begin
          if (gap_last) st <= S_WAIT;
          else gcnt <= gcnt + GW'(1);
        end
        default: st <= S_HOLD;
      endcase

      if (start_burst) begin
        st   <= S_BURST;
        pcnt <= per - PW'(1);
        plen <= '0;
      end
    end
  end

  logic [HW-1:0] age;
  logic [GW-1:0] idle_len;
  logic [PW-1:0] sp;
  logic          had;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      age      <= '0;
      idle_len <= GW'(GAP_CYC);
      sp       <= '0;
      had      <= 1'b0;
    end else begin
      if (age != HW'(HOLDOFF_CYC)) age <= age + HW'(1);
      if (burst_active) idle_len <= '0;
      else if (idle_len != GW'(GAP_CYC)) idle_len <= idle_len + GW'(1);
      if (xfer_pulse || start_burst) sp <= PW'(1);
      else if (sp != PW'(PER_MAX + 1)) sp <= sp + PW'(1);
      if (start_burst) had <= 1'b0;
      else if (xfer_pulse) had <= 1'b1;
    end
  end

  a_r1_holdoff: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(burst_active) |-> age == HW'(HOLDOFF_CYC));
  a_r5_min_gap: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(burst_active) |-> idle_len == GW'(GAP_CYC));
  a_r6_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_pulse && had) |-> (sp >= PW'(PER_MIN) && sp <= PW'(PER_MAX)));
  a_r7_eob_ends: assert property (@(posedge clk) disable iff (!rst_n)
    (burst_active && eob) |=> !burst_active);
  a_r8_ovf_ends: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> !burst_active);
  a_r9_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_pulse |=> !xfer_pulse);
endmodule

// File: tb/burst_sched_bench.sv
module burst_sched_bench;
  localparam int HOLD = 200, GAP = 25, STO = 1000, PMIN = 6, PMAX = 9, MAXP = 40;

  logic clk = 0, rst_n = 0, sync_in = 0, eob = 0;
  logic burst_active, xfer_pulse, overflow;

  burst_sched #(.HOLDOFF_CYC(HOLD), .GAP_CYC(GAP), .SYNC_TO_CYC(STO),
    .PER_MIN(PMIN), .PER_MAX(PMAX), .MAX_PULSES(MAXP)) u_burst_sched (
    .clk(clk), .rst_n(rst_n), .sync_in(sync_in), .eob(eob),
    .burst_active(burst_active), .xfer_pulse(xfer_pulse), .overflow(overflow));

  always #2.5 clk = ~clk;

  int cyc = 0, nchk = 0, nfail = 0;
  always @(posedge clk) if (rst_n) cyc <= cyc + 1;

  int start_c = 0, end_c = 0, lo_len = 0, hi_len = 0, s2s = 0, lat = 0;
  int pulses = 0, last_p = 0, nstarts = 0, nends = 0, ovf_cnt = 0;
  int first_off = 0, first_sp = 0, nspc = 0, badsp = 0, bad = 0, eob_n = 5;
  int last_rise = -100000, sync_period = 0;
  bit pb = 0, pp = 0, distinct = 0;

  always @(negedge clk) if (rst_n) begin
    if (burst_active && !pb) begin
      lo_len = cyc - end_c; s2s = cyc - start_c; lat = cyc - last_rise;
      start_c = cyc; nstarts++; pulses = 0;
    end
    if (!burst_active && pb) begin
      hi_len = cyc - start_c; end_c = cyc; nends++; eob = 0;
    end
    if (xfer_pulse) begin
      if (!burst_active || pp) bad++;
      if (pulses == 0) first_off = cyc - start_c;
      else begin
        if (cyc - last_p < PMIN || cyc - last_p > PMAX) badsp++;
        if (nspc == 0) first_sp = cyc - last_p;
        else if (cyc - last_p != first_sp) distinct = 1;
        nspc++;
      end
      last_p = cyc; pulses++;
      if (pulses == eob_n) eob = 1;
    end
    if (overflow) ovf_cnt++;
    pb = burst_active; pp = xfer_pulse;
  end

  initial forever begin
    if (sync_period > 0) begin
      @(posedge clk); #1 sync_in = 1; last_rise = cyc;
      repeat (4) @(posedge clk); #1 sync_in = 0;
      repeat (sync_period - 5) @(posedge clk);
    end else @(posedge clk);
  end

  task automatic chk(bit ok, string req, int act, int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_starts(int n);
    int t = nstarts + n;
    while (nstarts < t) @(posedge clk);
  endtask

  task automatic wait_ends(int n);
    int t = nends + n;
    while (nends < t) @(posedge clk);
  endtask

  task automatic finish_run;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(0, "watchdog", cyc, 0);
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    chk(!burst_active && !xfer_pulse && !overflow, "R9 reset", burst_active, 0);
    #1 rst_n = 1;
    wait_starts(1);
    chk(start_c == HOLD, "R1 first burst", start_c, HOLD);

    wait_ends(4);
    chk(lo_len == GAP, "R2 free gap", lo_len, GAP);
    chk(pulses == 5, "R7 eob end", pulses, 5);
    chk(first_off >= PMIN - 1 && first_off <= PMAX - 1, "R6 first pulse", first_off, PMIN - 1);
    chk(badsp == 0, "R6 spacing", badsp, 0);
    chk(distinct, "R6 dither", distinct, 1);
    chk(bad == 0, "R9 strobe", bad, 0);

    eob_n = 1000;
    wait_ends(1);
    chk(pulses == MAXP, "R8 max pulses", pulses, MAXP);
    chk(ovf_cnt == 1, "R8 overflow", ovf_cnt, 1);
    eob_n = 5;

    sync_period = 300;
    wait_starts(4);
    chk(s2s == 300, "R3 sync period", s2s, 300);
    chk(lat >= 2 && lat <= 4, "R3 sync latency", lat, 3);

    sync_period = 40;
    wait_starts(3);
    for (int i = 0; i < 4; i++) begin
      wait_starts(1);
      chk(lat >= 2 && lat <= 4, "R5 trigger on edge", lat, 3);
      chk(lo_len >= GAP, "R5 gap kept", lo_len, GAP);
      chk(s2s >= 80 && s2s % 40 == 0, "R5 edges skipped", s2s, 80);
    end

    sync_period = 0;
    do wait_starts(1); while (lat < 10);
    chk(lat >= STO + 3 && lat <= STO + 5, "R4 loss fallback", lat, STO + 4);
    wait_starts(2);
    chk(lo_len == GAP, "R4 free again", lo_len, GAP);
    chk(badsp == 0 && bad == 0, "R6 R9 overall", badsp + bad, 0);
    finish_run();
  end
endmodule